// File: doc/BRIEF.md
# Serial Control Register Interface

This block is a chip-select framed serial slave through which a host controller programs a four-channel line device. Every transfer is exactly eight bits long. The host pulls chip select low and clocks the bits in, most significant bit first. It then raises chip select again. The first bit of each byte, together with a mode field and address fields kept from an earlier configuration write, decides where the byte goes. The byte can land in the configuration register, in one of the per-channel transmit or receive time-slot registers, or in a per-channel line-signaling control register.

Reads are not requested by a direction bit. A configuration write that selects the signaling mode arms every following transfer as a read. During an armed transfer the block shifts out a status byte for the selected channel. That byte is built from the channel's signaling output levels, its two signaling I/O pins, and the first I/O pin of channels 1 to 3.

Serial capture runs on the control clock, which has no fixed relation to the system clock. A completed byte is handed to the system-clock domain by a toggle handshake, and there it is decoded and applied. All register contents are exposed as flat vectors for the rest of the device. The data output is given as a value plus an enable, so that a pad cell can tri-state it.

Top module: `ctl_serial_regs`

## Requirements
- R1: After reset, the configuration register is 8'h00, every time-slot register is zero, and every signaling control register is zero. A zero control register means all signaling outputs are low, all I/O drive levels are low and all I/O directions are input. `sdo_en` is low.
- R2: A completed byte whose first (most significant) bit is 1 is written whole into the configuration register, whatever the current mode. Configuration bits [3:2] select the channel, bits [1:0] select the slot register and bits [6:4] are the mode field.
- R3: With configuration bit 6 clear, a completed byte whose first bit is 0 writes its bits [6:0] into a slot register of the selected channel. Select code 2'b00 picks the transmit slot and 2'b01 picks the receive slot. Codes 2'b10 and 2'b11 change no slot register.
- R4: With mode field 3'b101, a completed byte whose first bit is 0 writes its bits [6:0] into the selected channel's control register. Bits [2:0] set that channel's three signaling outputs, bits [4:3] set its two I/O drive levels, and bits [6:5] set its two I/O directions (1 = output).
- R5: With configuration bit 6 set and a mode field other than 3'b101, a byte whose first bit is 0 changes no register.
- R6: While the mode field is 3'b101, each transfer is a read. `sdo_en` is high while chip select is low. Status bit 7 appears on `sdo` at the first rising control-clock edge, and each later rising edge presents the next lower bit. The status layout is [7:5] = control bits [2:0] of the selected channel and [4:3] = that channel's I/O pins {pin1, pin0}. When the mode field is anything else, `sdo_en` stays low.
- R7: Status bits [2:0] are always I/O pin 0 of channels 3, 2 and 1 (bit 0 = channel 1), whichever channel is selected.
- R8: `sdo_en` is low whenever chip select is high.
- R9: A transfer in which chip select rises before eight falling control-clock edges changes no register.
- R10: Each completed byte produces exactly one single-cycle write in the system domain. That write takes effect within four system clocks of the eighth falling control-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial control clock (idle low) |
| csn | input | 1 | Active-low chip select framing a transfer |
| sdi | input | 1 | Serial data in, sampled on falling `sclk` |
| sdo | output | 1 | Serial data out, changed on rising `sclk` |
| sdo_en | output | 1 | Output enable for `sdo` (tri-state control) |
| io_in | input | 8 | Signaling I/O pin levels, two per channel, channel c at [2c+1:2c] |
| cfg_q | output | 8 | Configuration register |
| tx_slot | output | 28 | Transmit slot numbers, 7 bits per channel |
| rx_slot | output | 28 | Receive slot numbers, 7 bits per channel |
| sig_out | output | 12 | Signaling output levels, 3 per channel |
| io_out | output | 8 | Signaling I/O drive levels, 2 per channel |
| io_dir | output | 8 | Signaling I/O directions, 2 per channel, 1 = output |

## Verification
The hardest case to reach from the ports is a read. No single transfer can request one. The stimulus first sends a configuration byte with the signaling mode, and only the next transfer shifts status out. In that same transfer the host's byte may also rewrite the control register that the status reflects. The bench therefore fixes the expected status when chip select falls, checks it bit by bit at mid-high of each control clock, and then applies the write to its model. It sends transfers cut off after five and seven bits, with contents that would have changed registers. It confirms that nothing moves. It also compares all registers every system clock outside transfer windows, so a late or doubled handshake shows up.

// File: rtl/ctl_serial_pkg.sv
`timescale 1ns/1ps
package ctl_serial_pkg;
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);
  localparam int BYTE_W = 8;
  localparam int SLOT_W = BYTE_W - 1;
  localparam int CTL_W  = BYTE_W - 1;
  localparam int SIG_W  = 3;
  localparam int IO_W   = 2;
  localparam int CNT_W  = $clog2(BYTE_W) + 1;
  localparam logic [2:0] MODE_SIG = 3'b101;
  localparam logic [1:0] SEL_TX   = 2'b00;
  localparam logic [1:0] SEL_RX   = 2'b01;

  typedef enum logic [1:0] {ACT_NONE, ACT_CFG, ACT_SLOT, ACT_SIG} act_e;

  // Where a completed byte goes, given the current configuration.
  function automatic act_e decode_act(input logic [BYTE_W-1:0] b, input logic [BYTE_W-1:0] cfg);
    if (b[BYTE_W-1])              return ACT_CFG;
    if (cfg[6:4] == MODE_SIG)     return ACT_SIG;
    if (!cfg[6] && (cfg[1:0] == SEL_TX || cfg[1:0] == SEL_RX)) return ACT_SLOT;
    return ACT_NONE;
  endfunction

  // Status byte layout: {sig levels, own I/O pair, pin0 of channels 3..1}.
  function automatic logic [BYTE_W-1:0] status_of(input logic [SIG_W-1:0] sig,
                                                   input logic [IO_W-1:0] io_pair,
                                                   input logic [NCH-2:0] io0_hi);
    return {sig, io_pair, io0_hi};
  endfunction
endpackage

// File: rtl/scr_shift.sv
`timescale 1ns/1ps
module scr_shift
  import ctl_serial_pkg::*;
(
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              csn,
  input  logic              sdi,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sdo,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_tog
);
  logic              clr;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] in_sh;
  logic [BYTE_W-2:0] out_sh;
  logic              loaded;
  logic              last_bit;

  assign clr      = csn | ~rst_n;
  assign last_bit = (bit_cnt == CNT_W'(BYTE_W - 1));

  // Input capture on falling edges; counter frozen once the byte is full.
  always_ff @(negedge sclk or posedge clr) begin
    if (clr) begin
      bit_cnt <= '0;
      in_sh   <= '0;
    end else if (bit_cnt < CNT_W'(BYTE_W)) begin
      in_sh   <= {in_sh[BYTE_W-3:0], sdi};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // Completed byte held here; the toggle announces it to the system domain.
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      rx_tog  <= 1'b0;
    end else if (!csn && last_bit) begin
      rx_byte <= {in_sh, sdi};
      rx_tog  <= ~rx_tog;
    end
  end

  // Output shifting on rising edges, MSB first.
  always_ff @(posedge sclk or posedge clr) begin
    if (clr) begin
      sdo    <= 1'b0;
      out_sh <= '0;
      loaded <= 1'b0;
    end else if (!loaded) begin
      {sdo, out_sh} <= tx_byte;
      loaded        <= 1'b1;
    end else begin
      sdo    <= out_sh[BYTE_W-2];
      out_sh <= {out_sh[BYTE_W-3:0], 1'b0};
    end
  end

  // R9
  cnt_bound_chk: assert property (@(negedge sclk) disable iff (clr) bit_cnt <= CNT_W'(BYTE_W));
endmodule

// File: rtl/scr_sync.sv
`timescale 1ns/1ps
module scr_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);
  logic [2:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], tog_in};
  end

  assign pulse = sync_q[1] ^ sync_q[2];

  // R10
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) pulse |=> !pulse);
endmodule

// File: rtl/scr_regs.sv
`timescale 1ns/1ps
module scr_regs
  import ctl_serial_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_pulse,
  input  logic [BYTE_W-1:0]       wr_byte,
  output logic [BYTE_W-1:0]       cfg_q,
  output logic [NCH*SLOT_W-1:0]   tx_flat,
  output logic [NCH*SLOT_W-1:0]   rx_flat,
  output logic [NCH*CTL_W-1:0]    ctl_flat
);
  act_e            act;
  logic [CH_W-1:0] ch_sel;
  logic [SLOT_W-1:0] tx_r  [NCH];
  logic [SLOT_W-1:0] rx_r  [NCH];
  logic [CTL_W-1:0]  ctl_r [NCH];

  assign act    = decode_act(wr_byte, cfg_q);
  assign ch_sel = cfg_q[3:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cfg_q <= '0;
    else if (wr_pulse && act == ACT_CFG) cfg_q <= wr_byte;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = wr_pulse && (ch_sel == CH_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_r[c]  <= '0;
        rx_r[c]  <= '0;
        ctl_r[c] <= '0;
      end else if (hit) begin
        if (act == ACT_SLOT && cfg_q[1:0] == SEL_TX) tx_r[c]  <= wr_byte[SLOT_W-1:0];
        if (act == ACT_SLOT && cfg_q[1:0] == SEL_RX) rx_r[c]  <= wr_byte[SLOT_W-1:0];
        if (act == ACT_SIG)                          ctl_r[c] <= wr_byte[CTL_W-1:0];
      end
    end

    assign tx_flat[c*SLOT_W +: SLOT_W] = tx_r[c];
    assign rx_flat[c*SLOT_W +: SLOT_W] = rx_r[c];
    assign ctl_flat[c*CTL_W +: CTL_W]  = ctl_r[c];
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !wr_pulse |=> $stable(cfg_q));
  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse && wr_byte[BYTE_W-1] |=> cfg_q == $past(wr_byte));
  // R4
  sig_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse && wr_byte[BYTE_W-1] |=> $stable(ctl_flat));
  // R5
  slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse && !wr_byte[BYTE_W-1] && cfg_q[6] |=> $stable(tx_flat) && $stable(rx_flat));
endmodule

// File: rtl/ctl_serial_regs.sv
`timescale 1ns/1ps
module ctl_serial_regs
  import ctl_serial_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  csn,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  sdo_en,
  input  logic [NCH*IO_W-1:0]   io_in,
  output logic [BYTE_W-1:0]     cfg_q,
  output logic [NCH*SLOT_W-1:0] tx_slot,
  output logic [NCH*SLOT_W-1:0] rx_slot,
  output logic [NCH*SIG_W-1:0]  sig_out,
  output logic [NCH*IO_W-1:0]   io_out,
  output logic [NCH*IO_W-1:0]   io_dir
);
  logic [BYTE_W-1:0]    rx_byte;
  logic                 rx_tog;
  logic                 wr_pulse;
  logic [NCH*CTL_W-1:0] ctl_flat;
  logic [BYTE_W-1:0]    status_byte;
  logic                 rd_arm;
  logic [SIG_W-1:0]     sig_ch [NCH];
  logic [IO_W-1:0]      pair_ch [NCH];
  logic [NCH-2:0]       io0_hi;

  scr_shift u_shift (
    .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
    .tx_byte(status_byte), .sdo(sdo), .rx_byte(rx_byte), .rx_tog(rx_tog)
  );

  scr_sync u_sync (.clk(clk), .rst_n(rst_n), .tog_in(rx_tog), .pulse(wr_pulse));

  scr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_byte(rx_byte),
    .cfg_q(cfg_q), .tx_flat(tx_slot), .rx_flat(rx_slot), .ctl_flat(ctl_flat)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign sig_ch[c]                 = ctl_flat[c*CTL_W +: SIG_W];
    assign pair_ch[c]                = io_in[c*IO_W +: IO_W];
    assign sig_out[c*SIG_W +: SIG_W] = ctl_flat[c*CTL_W +: SIG_W];
    assign io_out[c*IO_W +: IO_W]    = ctl_flat[c*CTL_W + SIG_W +: IO_W];
    assign io_dir[c*IO_W +: IO_W]    = ctl_flat[c*CTL_W + SIG_W + IO_W +: IO_W];
    if (c > 0) begin : g_hi
      assign io0_hi[c-1] = io_in[c*IO_W];
    end
  end

  assign rd_arm      = (cfg_q[6:4] == MODE_SIG);
  assign status_byte = status_of(sig_ch[cfg_q[3:2]], pair_ch[cfg_q[3:2]], io0_hi);
  assign sdo_en      = ~csn & rd_arm;
endmodule

// File: tb/ctl_serial_regs_tb.sv
`timescale 1ns/1ps
module ctl_serial_regs_tb;
  localparam int HALF = 40;
  logic clk = 1'b0, rst_n = 1'b1, sclk = 1'b0, csn = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  logic [7:0]  io_in = 8'h00;
  logic [7:0]  cfg_q;
  logic [27:0] tx_slot, rx_slot;
  logic [11:0] sig_out;
  logic [7:0]  io_out, io_dir;

  int checks = 0, errors = 0;
  bit busy = 1'b1, done = 1'b0;
  logic [7:0] m_cfg;
  logic [7:0] m_tx [4];
  logic [7:0] m_rx [4];
  logic [7:0] m_ctl [4];

  always #4 clk = ~clk;

  ctl_serial_regs u_dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .io_in(io_in), .cfg_q(cfg_q), .tx_slot(tx_slot),
    .rx_slot(rx_slot), .sig_out(sig_out), .io_out(io_out), .io_dir(io_dir));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [27:0] pack_slots(input bit rx);
    logic [27:0] v = '0;
    for (int c = 0; c < 4; c++) v[c*7 +: 7] = rx ? m_rx[c][6:0] : m_tx[c][6:0];
    return v;
  endfunction

  task automatic cmp_all(input string tag);
    logic [11:0] es = '0;
    logic [7:0] eo = '0, ed = '0;
    for (int c = 0; c < 4; c++) begin
      es[c*3 +: 3] = m_ctl[c][2:0];
      eo[c*2 +: 2] = m_ctl[c][4:3];
      ed[c*2 +: 2] = m_ctl[c][6:5];
    end
    chk(cfg_q == m_cfg, {tag, " R2 cfg"}, 32'(cfg_q), 32'(m_cfg));
    chk(tx_slot == pack_slots(0), {tag, " R3 tx"}, 32'(tx_slot), 32'(pack_slots(0)));
    chk(rx_slot == pack_slots(1), {tag, " R3 rx"}, 32'(rx_slot), 32'(pack_slots(1)));
    chk({sig_out, io_out, io_dir} == {es, eo, ed}, {tag, " R4 ctl"},
        32'({sig_out, io_out, io_dir}), 32'({es, eo, ed}));
  endtask

  function automatic logic [7:0] exp_status(input int ch);
    return {m_ctl[ch][2:0], io_in[2*ch+1], io_in[2*ch], io_in[6], io_in[4], io_in[2]};
  endfunction

  // Reference decode, written as a plain case analysis.
  task automatic apply(input logic [7:0] b);
    int ch = int'(m_cfg[3:2]);
    if (b[7] == 1'b1) m_cfg = b;
    else if (m_cfg[6:4] == 3'b101) m_ctl[ch] = {1'b0, b[6:0]};
    else if (m_cfg[6] == 1'b0) begin
      case (m_cfg[1:0])
        2'b00: m_tx[ch] = {1'b0, b[6:0]};
        2'b01: m_rx[ch] = {1'b0, b[6:0]};
        default: ;
      endcase
    end
  endtask

  task automatic xfer(input logic [7:0] b, input int nbits);
    bit rd;
    logic [7:0] st;
    busy = 1'b1;
    rd = (m_cfg[6:4] == 3'b101);
    st = exp_status(int'(m_cfg[3:2]));
    csn = 1'b0;
    #HALF;
    for (int i = 0; i < nbits; i++) begin
      sdi = b[7-i];
      sclk = 1'b1;
      #(HALF/2);
      chk(sdo_en == rd, "R6 sdo_en during transfer", 32'(sdo_en), 32'(rd));
      if (rd) chk(sdo == st[7-i], "R6/R7 status bit", 32'(sdo), 32'(st[7-i]));
      #(HALF/2);
      sclk = 1'b0;
      #HALF;
    end
    #10;
    if (nbits == 8) apply(b);
    csn = 1'b1;
    #1;
    chk(sdo_en == 1'b0, "R8 sdo_en with csn high", 32'(sdo_en), 32'd0);
    #(8*HALF);
    busy = 1'b0;
  endtask

  // Per-clock comparison with the model outside transfers (R10 latency).
  always @(negedge clk) if (!busy && !done) cmp_all("R10 settled");

  initial begin
    m_cfg = '0;
    for (int c = 0; c < 4; c++) begin m_tx[c] = '0; m_rx[c] = '0; m_ctl[c] = '0; end
    #2 rst_n = 1'b0; csn = 1'b1;
    #40 rst_n = 1'b1;
    #20;
    cmp_all("R1 reset");
    chk(sdo_en == 1'b0, "R1 sdo_en reset", 32'(sdo_en), 32'd0);
    busy = 1'b0;
    #50;
    // R3: every channel, both directions, including the top slot value.
    for (int c = 0; c < 4; c++) begin
      xfer({1'b1, 3'b000, 2'(c), 2'b00}, 8);
      xfer({1'b0, 7'(c*17 + 3)}, 8);
      xfer({1'b1, 3'b000, 2'(c), 2'b01}, 8);
      xfer({1'b0, (c == 3) ? 7'h7F : 7'(c*9 + 40)}, 8);
    end
    cmp_all("R3 slots");
    // R3: select codes 10 and 11 write nothing.
    xfer(8'b1000_0110, 8); xfer(8'h55, 8); cmp_all("R3 code10");
    xfer(8'b1000_1011, 8); xfer(8'h2A, 8); cmp_all("R3 code11");
    // R5: bit 6 set, mode other than 101.
    xfer(8'b1100_0100, 8); xfer(8'h33, 8); cmp_all("R5 mode100");
    xfer(8'b1111_1000, 8); xfer(8'h66, 8); cmp_all("R5 mode111");
    xfer(8'b1110_0001, 8); xfer(8'h7E, 8); cmp_all("R5 mode110");
    // R4/R6/R7: signaling mode, read armed, control writes per channel.
    for (int c = 0; c < 4; c++) begin
      io_in = 8'(8'hA5 ^ (c * 8'h3C));
      xfer({1'b1, 3'b101, 2'(c), 2'b00}, 8);
      xfer({1'b0, 7'(7'h5B ^ 7'(c * 19))}, 8);
      xfer(8'h00, 8);
      xfer({1'b0, 7'(7'h26 + 7'(c))}, 8);
      cmp_all("R4 ctl");
    end
    // R7: low status bits on channel 0 and channel 2 with distinct pin patterns.
    io_in = 8'b0101_0100; xfer(8'b1101_0000, 8); xfer(8'h07, 8);
    io_in = 8'b0001_0000; xfer(8'h12, 8);
    io_in = 8'b0100_0101; xfer(8'b1101_1000, 8); xfer(8'h61, 8);
    // R2: leading-1 byte while read is armed still loads the configuration.
    xfer(8'b1000_0100, 8); cmp_all("R2 leave read mode");
    // R9: cut-short transfers leave everything unchanged.
    xfer(8'b1101_1100, 5); cmp_all("R9 short cfg");
    xfer(8'h2F, 7); cmp_all("R9 short slot");
    xfer(8'h11, 8); cmp_all("R9 full after short");
    #200;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule